// File: doc/BRIEF.md
# Per-Rank Rolling Activate Limiter

This block sits beside a DRAM command scheduler and caps how many row activates each rank may receive within a rolling span of clock cycles. Each cycle the scheduler presents the rank of its candidate activate. In that same cycle the block replies whether issuing the activate keeps the rank within its budget of four. When the scheduler really issues the activate, it raises a commit strobe in that cycle, and the block records it in the rank's history.

The window length is chosen by a 2-bit code and limited to a small set of clock counts. The longest setting is the conservative one. The limit applies only while a throttle-enable input is high. The window slides cycle by cycle rather than stepping in fixed blocks, so an activate stops counting exactly when it has aged past the window length. A refused activate is never queued inside the block. The scheduler simply does not issue it and may ask again later.

The request is a query, not a data stream. There is no valid/ready pair and no back-pressure. `act_ok` is a plain combinational answer, and `commit` is a one-cycle strobe that the scheduler owns.

Top module: `act_window_limiter`

## Requirements
- R1: With `thr_en` high, a rank that already has four recorded activates, the oldest of them less than W cycles old, gives `act_ok` low. No rank ever has more than four accepted commits in any W consecutive cycles.
- R2: `win_code` selects W as follows: 2'b00 gives 10 cycles, 2'b01 gives 13, 2'b10 gives 15 and 2'b11 gives 20. An activate committed in cycle c counts through cycle c+W-1, and from cycle c+W on it no longer blocks the rank.
- R3: `act_ok` depends combinationally on `req_rank` and the current history, and is valid in the same cycle as the request.
- R4: With `thr_en` low, `act_ok` is high for every rank. Commits made while `thr_en` is low are still recorded, and they limit the rank once `thr_en` returns high.
- R5: A `commit` in a cycle where `act_ok` is low has no effect on any history.
- R6: The history of each rank is independent. Commits to one rank never change `act_ok` for another.
- R7: The window length in use is the one selected by `win_code` at the previous clock edge, and the stored history is kept across a code change. During reset and in the first cycle after it, W is 20.
- R8: A synchronous reset (`rst` high at a clock edge) clears every history, so every rank is allowed right after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| thr_en | input | 1 | Applies the activate limit when high |
| win_code | input | 2 | Window length select (10/13/15/20 cycles) |
| req_rank | input | RANK_W | Rank of the candidate activate |
| commit | input | 1 | Activate issued this cycle to `req_rank` |
| act_ok | output | 1 | Candidate activate is allowed this cycle |

## Verification
`act_ok` is due in the same cycle as its request. The bench therefore drives inputs just after the falling edge and compares `act_ok` one nanosecond later, well before the next rising edge. A commit and a window-code change both take effect at the next rising edge, so the bench's reference model updates its timestamp queues and its active window length only after that edge. The effect of each is then first checked in the following cycle. Because every window boundary is counted in whole cycles from the commit cycle, the checks land exactly on cycles c+W-1 (still refused) and c+W (allowed again) for each window code.

// File: rtl/actlim_pkg.sv
package actlim_pkg;
  localparam int MAX_WIN = 20;
  localparam int AGE_W   = $clog2(MAX_WIN + 1);

  typedef logic [AGE_W-1:0] age_t;

  typedef enum logic [1:0] {
    WIN_10 = 2'b00,
    WIN_13 = 2'b01,
    WIN_15 = 2'b10,
    WIN_20 = 2'b11
  } win_code_e;

  typedef struct packed {
    logic vld;
    age_t age;
  } slot_t;

  function automatic age_t win_len_of(win_code_e c);
    case (c)
      WIN_10:  win_len_of = age_t'(10);
      WIN_13:  win_len_of = age_t'(13);
      WIN_15:  win_len_of = age_t'(15);
      default: win_len_of = age_t'(MAX_WIN);
    endcase
  endfunction

  function automatic slot_t slot_aged(slot_t s);
    slot_t o;
    o = s;
    if (s.vld && (s.age != {AGE_W{1'b1}}))
      o.age = s.age + age_t'(1);
    return o;
  endfunction
endpackage

// File: rtl/actlim_win_reg.sv
module actlim_win_reg
  import actlim_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] win_code,
  output age_t       win_len
);
  age_t len_q;

  always_ff @(posedge clk) begin
    if (rst) len_q <= age_t'(MAX_WIN);
    else     len_q <= win_len_of(win_code_e'(win_code));
  end

  assign win_len = len_q;
endmodule

// File: rtl/actlim_rank_hist.sv
module actlim_rank_hist
  import actlim_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic rec,
  input  age_t win_len,
  output logic blocked
);
  slot_t slot_q [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
    end else if (rec) begin
      slot_q[0] <= '{vld: 1'b1, age: age_t'(1)};
      for (int i = 1; i < DEPTH; i++) slot_q[i] <= slot_aged(slot_q[i-1]);
    end else begin
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= slot_aged(slot_q[i]);
    end
  end

  assign blocked = slot_q[DEPTH-1].vld && (slot_q[DEPTH-1].age < win_len);
endmodule

// File: rtl/act_window_limiter.sv
module act_window_limiter
  import actlim_pkg::*;
#(
  parameter int N_RANKS   = 4,
  parameter int ACT_LIMIT = 4,
  parameter int RANK_W    = (N_RANKS > 1) ? $clog2(N_RANKS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              thr_en,
  input  logic [1:0]        win_code,
  input  logic [RANK_W-1:0] req_rank,
  input  logic              commit,
  output logic              act_ok
);
  age_t               win_len;
  logic [N_RANKS-1:0] blocked;
  logic [N_RANKS-1:0] rec;

  actlim_win_reg u_win (
    .clk      (clk),
    .rst      (rst),
    .win_code (win_code),
    .win_len  (win_len)
  );

  assign act_ok = !thr_en || !blocked[req_rank];

  for (genvar r = 0; r < N_RANKS; r++) begin : g_rank
    assign rec[r] = commit && act_ok && (req_rank == RANK_W'(r));

    actlim_rank_hist #(.DEPTH(ACT_LIMIT)) u_hist (
      .clk     (clk),
      .rst     (rst),
      .rec     (rec[r]),
      .win_len (win_len),
      .blocked (blocked[r])
    );
  end
endmodule

// File: rtl/act_window_limiter_chk.sv
module act_window_limiter_chk #(
  parameter int RANK_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              thr_en,
  input logic [1:0]        win_code,
  input logic [RANK_W-1:0] req_rank,
  input logic              commit,
  input logic              act_ok
);
  logic [2:0] since_rst;
  logic       took;

  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
  end

  assign took = commit && act_ok;

  AST_RESET_ALLOWS: assert property (@(posedge clk) rst |=> act_ok); // R8

  AST_BYPASS_ALLOWS: assert property (@(posedge clk) disable iff (rst)
    !thr_en |-> act_ok); // R4

  AST_FIFTH_REFUSED: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 3'd4 && thr_en &&
     $past(took, 1) && $past(took, 2) && $past(took, 3) && $past(took, 4) &&
     $past(req_rank, 1) == req_rank && $past(req_rank, 2) == req_rank &&
     $past(req_rank, 3) == req_rank && $past(req_rank, 4) == req_rank)
    |-> !act_ok); // R1

  AST_OK_KNOWN: assert property (@(posedge clk) disable iff (rst)
    !$isunknown({thr_en, req_rank}) |-> !$isunknown(act_ok)); // R3

  AST_CODE_KNOWN: assert property (@(posedge clk) disable iff (rst)
    !$isunknown(win_code)); // R2
endmodule

bind act_window_limiter act_window_limiter_chk #(.RANK_W(RANK_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .thr_en   (thr_en),
  .win_code (win_code),
  .req_rank (req_rank),
  .commit   (commit),
  .act_ok   (act_ok)
);

// File: tb/act_window_limiter_test.sv
`timescale 1ns/1ps
module act_window_limiter_test;
  localparam int NR = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       thr_en = 1'b0;
  logic [1:0] win_code = 2'b11;
  logic [1:0] req_rank = '0;
  logic       commit = 1'b0;
  logic       act_ok;

  int tests = 0;
  int fails = 0;
  int ts [NR][4];
  int cnt [NR];
  int cyc = 0;
  int wl_q = 20;

  always #2 clk = ~clk;

  act_window_limiter uut (
    .clk(clk), .rst(rst), .thr_en(thr_en), .win_code(win_code),
    .req_rank(req_rank), .commit(commit), .act_ok(act_ok)
  );

  function automatic int len_of(logic [1:0] c);
    case (c)
      2'b00: return 10;
      2'b01: return 13;
      2'b10: return 15;
      default: return 20;
    endcase
  endfunction

  function automatic logic model_ok(logic en, int r);
    if (!en) return 1'b1;
    if (cnt[r] < 4) return 1'b1;
    return ((cyc - ts[r][0]) >= wl_q);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; commit = 1'b0;
    @(posedge clk); @(posedge clk);
    for (int r = 0; r < NR; r++) cnt[r] = 0;
    wl_q = 20;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic step(input logic en, input logic [1:0] code, input int r,
                      input logic cm, input string tag);
    logic e;
    string t;
    @(negedge clk);
    thr_en = en; win_code = code; req_rank = 2'(r); commit = cm;
    #1;
    e = model_ok(en, r);
    t = tag;
    if (t == "") t = !en ? "R4" : (!e ? "R1" : "R2");
    tests++;
    if (act_ok !== e) begin
      fails++;
      $display("FAIL %s cyc=%0d rank=%0d act_ok=%0b expected=%0b", t, cyc, r, act_ok, e);
    end
    @(posedge clk);
    if (cm && e) begin
      if (cnt[r] == 4) begin
        for (int i = 0; i < 3; i++) ts[r][i] = ts[r][i+1];
        ts[r][3] = cyc;
      end else begin
        ts[r][cnt[r]] = cyc;
        cnt[r]++;
      end
    end
    wl_q = len_of(code);
    cyc++;
  endtask

  initial begin
    #(4.0 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    do_reset();
    // R8: every rank allowed straight after reset
    for (int r = 0; r < NR; r++) step(1, 2'b00, r, 0, "R8");
    // R3: four back-to-back commits to rank 0 answered in-cycle
    for (int i = 0; i < 4; i++) step(1, 2'b00, 0, 1, "R3");
    // R6: another rank unaffected
    step(1, 2'b00, 1, 0, "R6");
    // R5: commits while refused are ignored; R1 refusal through c+W-1
    for (int i = 0; i < 5; i++) step(1, 2'b00, 0, 1, "R5");
    // R2: release exactly at c+W for each entry
    for (int i = 0; i < 4; i++) step(1, 2'b00, 0, 0, "R2");
    // R4: bypass, with commits still recorded
    for (int i = 0; i < 4; i++) step(1, 2'b01, 2, 1, "");
    for (int i = 0; i < 3; i++) step(0, 2'b01, 2, 1, "R4");
    for (int i = 0; i < 4; i++) step(1, 2'b01, 2, 0, "R4");
    // R7: code change uses the old length for one more cycle
    for (int i = 0; i < 4; i++) step(1, 2'b11, 3, 1, "");
    for (int i = 0; i < 9; i++) step(1, 2'b11, 3, 0, "R7");
    step(1, 2'b00, 3, 0, "R7");
    step(1, 2'b00, 3, 0, "R7");
    for (int i = 0; i < 6; i++) step(1, 2'b10, 3, 0, "R7");
    // random traffic with a fixed seed
    void'($urandom(32'h5eed_0042));
    begin
      logic [1:0] code = 2'b01;
      for (int n = 0; n < 4000; n++) begin
        if (n == 2000) begin
          do_reset();
          for (int r = 0; r < NR; r++) step(1, code, r, 0, "R8");
        end
        if (($urandom % 50) == 0) code = 2'($urandom);
        step(($urandom % 10) != 0, code, int'($urandom % NR),
             ($urandom % 10) < 6, "");
      end
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule